// File: doc/BRIEF.md
# ADC Scan Sequencer

This block is the digital control logic that steps an analog-to-digital converter core through a range of input channels. A control interface supplies a software start strobe, a forced-termination strobe, a two-bit source select, a two-bit scan mode, and first and last channel numbers. The block turns those settings into activation decisions. It can be started by software, by a falling edge on an external trigger pin, or by a pulse from a timer. When several sources are enabled, the earliest event wins.

Toward the converter core the block issues a one-cycle start pulse together with the channel number. It takes back a one-cycle done pulse with the conversion result. Each accepted result is presented for one cycle on the result port. The block reports its state through a busy flag and the current channel. It also raises a one-cycle scan-complete flag each time the last channel of the range has been converted.

Four scan modes are offered:
- single scan that can be restarted while running;
- single scan that cannot be restarted while running;
- continuous scan;
- stepped scan, which converts one channel for each activation event.

Top module: `adc_scan_sequencer`

## Requirements
- R1: `srcSel` gates the activation sources. Bit 0 enables the external trigger pin and bit 1 enables the timer pulse; the software start strobe is always enabled. Reset value is 00 (software only). An event from a source that is not enabled has no effect: `busy` stays 0.
- R2: When several enabled events arrive in the same cycle, exactly one scan is started.
- R3: The external trigger acts on a falling edge of `extTrigN`. A pin that is already low when bit 0 of `srcSel` is set counts as a falling edge and starts a scan. A pin held low afterwards does not start another scan.
- R4: An accepted activation makes `busy` 1, `curCh` equal to `firstCh` and `convStart` 1 in the cycle after the event. `convStart` is never 1 while `busy` is 0.
- R5: With `modeSel` = 00, a start accepted during a scan restarts it. `curCh` returns to `firstCh` in the next cycle and a new conversion is launched.
- R6: With `modeSel` = 01, 10 or 11, an activation that arrives while a conversion is in flight is ignored.
- R7: In single modes (00, 01), channels `firstCh` through `lastCh` are converted in ascending order, one after another. `busy` falls in the cycle after the last done pulse.
- R8: If `lastCh` < `firstCh`, a scan converts only `firstCh`.
- R9: With `modeSel` = 10, the scan restarts at `firstCh` right after `lastCh` and keeps running until forced termination.
- R10: With `modeSel` = 11, each activation event converts one channel and then waits with `busy` = 1. The channel after `lastCh` is `firstCh`.
- R11: `stopWr` clears `busy` in the next cycle and has priority over any activation in the same cycle. A done pulse that arrives after termination produces no result and no scan-complete flag.
- R12: For each done pulse accepted during a conversion, `resultValid` is 1 for one cycle in the next cycle, with the data on `resultData`. `scanDone` is a one-cycle pulse in that same cycle whenever the converted channel was the last one of the range.
- R13: After reset, `busy`, `curCh`, `convStart`, `scanDone` and `resultValid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startWr | input | 1 | Software start strobe (one cycle) |
| stopWr | input | 1 | Forced termination strobe (one cycle) |
| srcSel | input | 2 | Activation source enables: bit0 external pin, bit1 timer |
| modeSel | input | 2 | Scan mode: 00 single+restart, 01 single, 10 continuous, 11 stepped |
| firstCh | input | CH_W | First channel of the range |
| lastCh | input | CH_W | Last channel of the range |
| extTrigN | input | 1 | External trigger pin, active on falling edge |
| timerTick | input | 1 | Timer underflow pulse |
| convDone | input | 1 | Conversion done pulse from the converter core |
| convData | input | DATA_W | Conversion result from the converter core |
| convStart | output | 1 | Start-conversion pulse to the converter core |
| convCh | output | CH_W | Channel to convert |
| busy | output | 1 | Scan in progress |
| curCh | output | CH_W | Channel currently being converted |
| resultValid | output | 1 | One-cycle result strobe |
| resultData | output | DATA_W | Latched conversion result |
| scanDone | output | 1 | One-cycle end-of-scan flag |

## Verification
Each result is due at a fixed delay:
- A start, trigger edge, timer pulse or termination strobe held over one rising edge shows up on `busy`, `curCh` and `convStart` just after that same edge. The bench reads them on the falling edge that closes the strobe.
- A done pulse from the stub core produces `resultValid`, `scanDone` and the next `convStart` one edge later. A falling-edge monitor logs those results.

The sequence checks wait for `busy` to drop and then for one extra falling edge before comparing the log, so that the final result is always recorded. Checks that something was ignored wait ten cycles and then confirm that the log and the completion count did not change.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE_RS = 2'b00,
    MODE_SINGLE    = 2'b01,
    MODE_CONT      = 2'b10,
    MODE_STEP      = 2'b11
  } scanMode_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_CONV = 2'b01,
    ST_WAIT = 2'b10
  } seqState_t;

  typedef struct packed {
    logic loadFirst;
    logic advance;
    logic capture;
  } dpStrobe_t;

endpackage

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startWr,
  input  logic       stopWr,
  input  logic [1:0] srcSel,
  input  logic [1:0] modeSel,
  input  logic       extTrigN,
  input  logic       timerTick,
  input  logic       convDone,
  input  logic       atEnd,
  output dpStrobe_t  strobe,
  output logic       convStart,
  output logic       busy,
  output logic       scanDone
);

  seqState_t state, nextState;
  scanMode_t mode;
  logic      extPrev;
  logic      extFall;
  logic      actEvent;
  logic      launch;
  logic      doneSet;

  assign mode = scanMode_t'(modeSel);

  // While the pin source is disabled, the history is held high.
  // Enabling it with the pin already low therefore reads as a falling edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extPrev <= 1'b1;
    else       extPrev <= srcSel[0] ? extTrigN : 1'b1;
  end

  assign extFall  = srcSel[0] & extPrev & ~extTrigN;
  assign actEvent = startWr | extFall | (srcSel[1] & timerTick);

  always_comb begin
    nextState = state;
    strobe    = '0;
    launch    = 1'b0;
    doneSet   = 1'b0;
    if (stopWr) begin
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (actEvent) begin
            strobe.loadFirst = 1'b1;
            launch           = 1'b1;
            nextState        = ST_CONV;
          end
        end
        ST_CONV: begin
          if (actEvent && mode == MODE_SINGLE_RS) begin
            strobe.loadFirst = 1'b1;
            strobe.capture   = convDone;
            launch           = 1'b1;
          end else if (convDone) begin
            strobe.capture = 1'b1;
            if (atEnd) begin
              doneSet = 1'b1;
              unique case (mode)
                MODE_CONT: begin
                  strobe.loadFirst = 1'b1;
                  launch           = 1'b1;
                end
                MODE_STEP: begin
                  strobe.loadFirst = 1'b1;
                  nextState        = ST_WAIT;
                end
                default: nextState = ST_IDLE;
              endcase
            end else begin
              strobe.advance = 1'b1;
              if (mode == MODE_STEP) nextState = ST_WAIT;
              else                   launch    = 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (actEvent) begin
            launch    = 1'b1;
            nextState = ST_CONV;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      convStart <= 1'b0;
      scanDone  <= 1'b0;
    end else begin
      state     <= nextState;
      convStart <= launch;
      scanDone  <= doneSet;
    end
  end

  assign busy = (state != ST_IDLE);

  // R4: a start pulse to the core only while a scan is active
  a_r4_start_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> busy);

  // R11: termination wins over everything in the same cycle
  a_r11_stop_priority: assert property (@(posedge clk) disable iff (!rstN)
    stopWr |=> (!busy && !convStart));

  // R12: completion flag only follows a done pulse from the core
  a_r12_done_after_core: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |-> $past(convDone));

  // R7: non-restartable single scan is idle once its completion flag shows
  a_r7_single_ends_idle: assert property (@(posedge clk) disable iff (!rstN)
    (scanDone && $past(modeSel) == 2'b01) |-> !busy);

  // R6: blocked modes ignore activations during a conversion
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && mode != MODE_SINGLE_RS && !convDone && !stopWr)
      |=> (state == ST_CONV && !convStart));

  // R10: the stepped mode holds until the next event
  a_r10_step_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !actEvent && !stopWr) |=> (state == ST_WAIT && !convStart));

endmodule

// File: rtl/adc_seq_dp.sv
`timescale 1ns/1ps
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int CH_W   = 5,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [CH_W-1:0]   firstCh,
  input  logic [CH_W-1:0]   lastCh,
  input  logic [DATA_W-1:0] convData,
  output logic [CH_W-1:0]   curCh,
  output logic              atEnd,
  output logic [DATA_W-1:0] resultData,
  output logic              resultValid
);

  logic [CH_W-1:0] endCh;

  // A reversed range collapses to the first channel alone.
  assign endCh = (lastCh < firstCh) ? firstCh : lastCh;
  assign atEnd = (curCh == endCh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 curCh <= '0;
    else if (strobe.loadFirst) curCh <= firstCh;
    else if (strobe.advance)   curCh <= curCh + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultData  <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strobe.capture;
      if (strobe.capture) resultData <= convData;
    end
  end

  // R7: a step moves exactly one channel up
  a_r7_step_by_one: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> (curCh == $past(curCh) + 1'b1));

  // R8: the control never steps beyond the effective end channel
  a_r8_no_step_past_end: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> !atEnd);

endmodule

// File: rtl/adc_scan_sequencer.sv
`timescale 1ns/1ps
module adc_scan_sequencer
  import adc_seq_pkg::*;
#(
  parameter int CH_W   = 5,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startWr,
  input  logic              stopWr,
  input  logic [1:0]        srcSel,
  input  logic [1:0]        modeSel,
  input  logic [CH_W-1:0]   firstCh,
  input  logic [CH_W-1:0]   lastCh,
  input  logic              extTrigN,
  input  logic              timerTick,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convData,
  output logic              convStart,
  output logic [CH_W-1:0]   convCh,
  output logic              busy,
  output logic [CH_W-1:0]   curCh,
  output logic              resultValid,
  output logic [DATA_W-1:0] resultData,
  output logic              scanDone
);

  dpStrobe_t strobe;
  logic      atEnd;

  adc_seq_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .startWr   (startWr),
    .stopWr    (stopWr),
    .srcSel    (srcSel),
    .modeSel   (modeSel),
    .extTrigN  (extTrigN),
    .timerTick (timerTick),
    .convDone  (convDone),
    .atEnd     (atEnd),
    .strobe    (strobe),
    .convStart (convStart),
    .busy      (busy),
    .scanDone  (scanDone)
  );

  adc_seq_dp #(.CH_W(CH_W), .DATA_W(DATA_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .firstCh     (firstCh),
    .lastCh      (lastCh),
    .convData    (convData),
    .curCh       (curCh),
    .atEnd       (atEnd),
    .resultData  (resultData),
    .resultValid (resultValid)
  );

  assign convCh = curCh;

endmodule

// File: tb/adc_scan_sequencer_tb.sv
`timescale 1ns/1ps
module adc_scan_sequencer_tb_top;

  localparam int CH_W   = 3;
  localparam int DATA_W = 10;
  localparam int NCH    = 1 << CH_W;
  localparam int LOGN   = 4096;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rstN;
  logic              startWr, stopWr, extTrigN, timerTick;
  logic [1:0]        srcSel, modeSel;
  logic [CH_W-1:0]   firstCh, lastCh;
  logic              convDone;
  logic [DATA_W-1:0] convData;
  logic              convStart, busy, resultValid, scanDone;
  logic [CH_W-1:0]   convCh, curCh;
  logic [DATA_W-1:0] resultData;

  adc_scan_sequencer #(.CH_W(CH_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .startWr(startWr), .stopWr(stopWr),
    .srcSel(srcSel), .modeSel(modeSel), .firstCh(firstCh), .lastCh(lastCh),
    .extTrigN(extTrigN), .timerTick(timerTick), .convDone(convDone),
    .convData(convData), .convStart(convStart), .convCh(convCh), .busy(busy),
    .curCh(curCh), .resultValid(resultValid), .resultData(resultData),
    .scanDone(scanDone)
  );

  function automatic logic [DATA_W-1:0] expData(int ch);
    return DATA_W'(ch * 37 + 5);
  endfunction

  // Behavioural converter core: a fixed latency, and a new start aborts the one in flight.
  logic [2:0]      stubCnt;
  logic [CH_W-1:0] stubCh;
  always @(posedge clk) begin
    if (!rstN) begin
      stubCnt  <= '0;
      convDone <= 1'b0;
      convData <= '0;
      stubCh   <= '0;
    end else begin
      convDone <= 1'b0;
      if (convStart) begin
        stubCnt <= 3'd3;
        stubCh  <= convCh;
      end else if (stubCnt != 0) begin
        stubCnt <= stubCnt - 1'b1;
        if (stubCnt == 1) begin
          convDone <= 1'b1;
          convData <= expData(int'(stubCh));
        end
      end
    end
  end

  // Result monitor
  logic [DATA_W-1:0] logv [LOGN];
  int logCount  = 0;
  int doneCount = 0;
  always @(negedge clk) begin
    if (rstN && resultValid) begin
      logv[logCount % LOGN] = resultData;
      logCount = logCount + 1;
    end
    if (rstN && scanDone) doneCount = doneCount + 1;
  end

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkEntry(input int idx, input int ch, input string req);
    check(logv[idx % LOGN] == expData(ch), req, int'(logv[idx % LOGN]), int'(expData(ch)));
  endtask

  task automatic pulseStart();
    @(negedge clk) startWr = 1'b1;
    @(negedge clk) startWr = 1'b0;
  endtask

  task automatic pulseStop();
    @(negedge clk) stopWr = 1'b1;
    @(negedge clk) stopWr = 1'b0;
  endtask

  task automatic pulseTimer();
    @(negedge clk) timerTick = 1'b1;
    @(negedge clk) timerTick = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic waitLog(input int target);
    for (int i = 0; i < 500 && logCount < target; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    int base, dbase, n;
    bit ok;
    rstN = 1'b0; startWr = 1'b0; stopWr = 1'b0; extTrigN = 1'b1; timerTick = 1'b0;
    srcSel = 2'b00; modeSel = 2'b01; firstCh = '0; lastCh = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13 reset values
    check(!busy && curCh == 0 && !convStart && !scanDone && !resultValid, "R13",
          {busy, convStart, scanDone, resultValid}, 0);

    // R7 and R8: sweep every first/last pair in a blocked single scan
    for (int f = 0; f < NCH; f++) begin
      for (int l = 0; l < NCH; l++) begin
        firstCh = CH_W'(f); lastCh = CH_W'(l);
        base = logCount; dbase = doneCount;
        pulseStart();
        check(busy && curCh == CH_W'(f), "R4", int'(curCh), f);
        waitIdle();
        n = (l >= f) ? (l - f + 1) : 1;
        ok = (logCount - base == n);
        for (int i = 0; i < n; i++)
          if (logv[(base + i) % LOGN] != expData(f + i)) ok = 1'b0;
        check(ok, (l >= f) ? "R7" : "R8", logCount - base, n);
        check(doneCount - dbase == 1 && !busy, "R12", doneCount - dbase, 1);
      end
    end

    // R1: timer and pin events have no effect when their sources are off
    firstCh = 3'd2; lastCh = 3'd3; modeSel = 2'b01;
    srcSel = 2'b00;
    pulseTimer();
    check(!busy, "R1", busy, 0);
    extTrigN = 1'b0;
    repeat (5) @(negedge clk);
    check(!busy, "R1", busy, 0);
    // R3: enabling the pin source while the pin is low starts a scan
    srcSel = 2'b01;
    @(negedge clk);
    check(busy && curCh == 3'd2, "R3", busy, 1);
    waitIdle();
    repeat (10) @(negedge clk);
    check(!busy, "R3", busy, 0);  // a pin held low does not start again
    extTrigN = 1'b1;
    @(negedge clk);
    // R3: a falling edge on the pin
    base = logCount;
    extTrigN = 1'b0;
    @(negedge clk);
    check(busy, "R3", busy, 1);
    waitIdle();
    extTrigN = 1'b1;
    check(logCount - base == 2, "R3", logCount - base, 2);
    // R1: timer enabled
    srcSel = 2'b10;
    pulseTimer();
    check(busy, "R1", busy, 1);
    waitIdle();

    // R2: all sources fire in the same cycle, so one scan only
    srcSel = 2'b11;
    base = logCount; dbase = doneCount;
    @(negedge clk) begin startWr = 1'b1; timerTick = 1'b1; extTrigN = 1'b0; end
    @(negedge clk) begin startWr = 1'b0; timerTick = 1'b0; end
    waitIdle();
    repeat (10) @(negedge clk);
    extTrigN = 1'b1;
    check(doneCount - dbase == 1 && logCount - base == 2, "R2", logCount - base, 2);
    srcSel = 2'b00;
    @(negedge clk);

    // R5: restart accepted in mode 00
    firstCh = 3'd0; lastCh = 3'd5; modeSel = 2'b00;
    base = logCount;
    pulseStart();
    waitLog(base + 2);
    pulseStart();
    check(curCh == 3'd0 && busy, "R5", int'(curCh), 0);
    waitIdle();
    ok = (logCount - base == 8);
    check(ok, "R5", logCount - base, 8);
    if (ok) begin
      checkEntry(base + 0, 0, "R5"); checkEntry(base + 1, 1, "R5");
      for (int i = 0; i < 6; i++) checkEntry(base + 2 + i, i, "R5");
    end

    // R6: restart ignored in mode 01
    modeSel = 2'b01;
    base = logCount;
    pulseStart();
    waitLog(base + 2);
    pulseStart();
    check(curCh == 3'd2, "R6", int'(curCh), 2);
    waitIdle();
    check(logCount - base == 6, "R6", logCount - base, 6);

    // R9: continuous mode wraps; R11: forced termination
    firstCh = 3'd5; lastCh = 3'd6; modeSel = 2'b10;
    base = logCount; dbase = doneCount;
    pulseStart();
    waitLog(base + 5);
    for (int i = 0; i < 5; i++) checkEntry(base + i, (i % 2 == 0) ? 5 : 6, "R9");
    check(busy && doneCount - dbase >= 2, "R9", doneCount - dbase, 2);
    pulseStop();
    check(!busy, "R11", busy, 0);
    base = logCount; dbase = doneCount;
    repeat (10) @(negedge clk);
    check(logCount == base && doneCount == dbase && !busy, "R11", logCount - base, 0);

    // R10: stepped mode, one channel for each timer event
    firstCh = 3'd1; lastCh = 3'd2; modeSel = 2'b11; srcSel = 2'b10;
    base = logCount; dbase = doneCount;
    pulseTimer();
    repeat (10) @(negedge clk);
    check(logCount - base == 1 && busy && curCh == 3'd2, "R10", int'(curCh), 2);
    checkEntry(base, 1, "R10");
    pulseTimer();
    repeat (10) @(negedge clk);
    check(logCount - base == 2 && curCh == 3'd1 && doneCount - dbase == 1, "R10",
          int'(curCh), 1);
    checkEntry(base + 1, 2, "R10");
    // R6: a second event during the conversion is ignored
    pulseTimer();
    pulseTimer();
    repeat (10) @(negedge clk);
    check(logCount - base == 3 && curCh == 3'd2, "R6", logCount - base, 3);
    pulseStop();
    check(!busy, "R11", busy, 0);

    // R11: termination and start written in the same cycle
    srcSel = 2'b00; modeSel = 2'b01;
    base = logCount;
    @(negedge clk) begin startWr = 1'b1; stopWr = 1'b1; end
    @(negedge clk) begin startWr = 1'b0; stopWr = 1'b0; end
    check(!busy && !convStart, "R11", busy, 0);
    repeat (10) @(negedge clk);
    check(logCount == base && !busy, "R11", logCount - base, 0);

    finishRun();
  end

endmodule